// File: doc/BRIEF.md
# Serial Add-and-Shift Unsigned Multiplier

This block multiplies two unsigned operands of `OPW` bits (default 4) into a product of `2*OPW` bits. It works serially, one multiplier bit per clock. A control state machine sequences a datapath of three registers: a left-shifting multiplicand register of product width, a right-shifting multiplier register of operand width, and an accumulator. A ripple adder built from one-bit full-adder cells feeds the accumulator.

The user drives both operands and raises `start_i`. The block detects the rising edge of `start_i` and captures the operands. It then runs `OPW` iterations. In each iteration the multiplicand is added into the accumulator when the current multiplier bit is 1. After the last iteration `done_o` goes high and the product is held until the next accepted start. A rising edge of `start_i` that arrives while a multiplication is running has no effect.

Reset is asynchronous and active low. Its release passes through a two-stage synchronizer inside the block.

Top module: `serial_mult`

## Requirements
- R1: While reset is active and after reset is released, `done_o` is 0 and `product_o` is 0 until a start is accepted.
- R2: When `done_o` is 1, `product_o` equals the unsigned product of the `a_i` and `b_i` values that were present when the start was accepted.
- R3: If a rising edge of `start_i` is sampled at clock edge E while the block is idle or done, `done_o` is 0 after edges E through E+OPW-1 and is 1 after edge E+OPW+... exactly after edge E+OPW.
- R4: While `done_o` is 1 and no new start is accepted, `done_o` stays 1 and `product_o` does not change.
- R5: `start_i` is edge-detected: holding it high across and after completion launches only one multiplication.
- R6: A rising edge of `start_i` sampled while a multiplication is running is ignored. The running result is unchanged and no second run follows.
- R7: A start accepted from the done state clears `done_o` and `product_o` to 0 after that same edge.
- R8: Changes on `a_i` and `b_i` after the accepting edge have no effect on the result.
- R9: The full operand range, including 0 and the all-ones operands (15*15 = 225 by default), gives the exact product with no carry out of the product width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all logic is rising-edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start request; its rising edge launches a multiplication |
| a_i | input | OPW | Multiplicand operand |
| b_i | input | OPW | Multiplier operand |
| product_o | output | 2*OPW | Accumulated product |
| done_o | output | 1 | End-of-operation flag |

## Verification
The embedded properties check on every cycle that the done state holds with a stable accumulator until a launch, that a launch clears the accumulator and the done flag, that the done state is entered only after the last iteration, and that no add ever carries out of the product width. Only the bench scenarios can show that the final value is the true product of the captured operands. The same holds for the exact cycle of completion and for the fact that a held or mid-run start changes nothing. These scenarios cover random operands, both extreme operands, a repeated start during a run and operand changes during a run.

// File: rtl/mul_pkg.sv
package mul_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } mul_state_e;
endpackage

// File: rtl/mul_fa.sv
module mul_fa (
  input  logic x_i,
  input  logic y_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  assign s_o = x_i ^ y_i ^ c_i;
  assign c_o = (x_i & y_i) | (c_i & (x_i ^ y_i));
endmodule

// File: rtl/mul_adder.sv
module mul_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W:0] carry;
  assign carry[0] = 1'b0;

  for (genvar g = 0; g < W; g++) begin : g_cell
    mul_fa u_fa (
      .x_i (x_i[g]),
      .y_i (y_i[g]),
      .c_i (carry[g]),
      .s_o (sum_o[g]),
      .c_o (carry[g+1])
    );
  end

  assign cout_o = carry[W];
endmodule

// File: rtl/mul_datapath.sv
module mul_datapath #(
  parameter int OPW = 4,
  localparam int PW = 2 * OPW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_i,
  input  logic           step_i,
  input  logic [OPW-1:0] a_i,
  input  logic [OPW-1:0] b_i,
  output logic [PW-1:0]  acc_o
);
  logic [PW-1:0]  mcd_q;
  logic [OPW-1:0] mr_q;
  logic [PW-1:0]  acc_q;
  logic [PW-1:0]  sum;
  logic           cout;
  logic           shift_en;
  logic           acc_en;
  logic [PW-1:0]  acc_d;

  mul_adder #(.W(PW)) u_add (
    .x_i    (acc_q),
    .y_i    (mcd_q),
    .sum_o  (sum),
    .cout_o (cout)
  );

  assign shift_en = load_i | step_i;
  assign acc_en   = load_i | (step_i & mr_q[0]);
  assign acc_d    = load_i ? '0 : sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcd_q <= '0;
      mr_q  <= '0;
    end else if (shift_en) begin
      if (load_i) begin
        mcd_q <= {{(PW-OPW){1'b0}}, a_i};
        mr_q  <= b_i;
      end else begin
        mcd_q <= {mcd_q[PW-2:0], 1'b0};
        mr_q  <= {1'b0, mr_q[OPW-1:1]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_d;
    end
  end

  assign acc_o = acc_q;

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && mr_q[0]) |-> !cout);

  p_clear_on_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (acc_q == '0));

  p_acc_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !step_i) |=> $stable(acc_q));
endmodule

// File: rtl/mul_ctrl.sv
module mul_ctrl
  import mul_pkg::*;
#(
  parameter int OPW = 4,
  localparam int CW = (OPW > 2) ? $clog2(OPW) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic done_o
);
  mul_state_e state_q, state_d;
  logic [CW-1:0] cnt_q;
  logic          start_q;
  logic          launch;
  logic          last_iter;

  assign launch    = start_i & ~start_q & (state_q != ST_RUN);
  assign last_iter = (cnt_q == CW'(OPW - 1));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (launch) state_d = ST_RUN;
      ST_RUN:  if (last_iter) state_d = ST_DONE;
      ST_DONE: if (launch) state_d = ST_RUN;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= start_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (launch) begin
      cnt_q <= '0;
    end else if (state_q == ST_RUN) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign load_o = launch;
  assign step_o = (state_q == ST_RUN);
  assign done_o = (state_q == ST_DONE);

  p_done_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !launch) |=> done_o);

  p_done_after_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> ($past(state_q) == ST_RUN && $past(cnt_q) == CW'(OPW - 1)));

  p_no_launch_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    step_o |=> (step_o || done_o));
endmodule

// File: rtl/serial_mult.sv
module serial_mult #(
  parameter int OPW = 4,
  localparam int PW = 2 * OPW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [OPW-1:0] a_i,
  input  logic [OPW-1:0] b_i,
  output logic [PW-1:0]  product_o,
  output logic           done_o
);
  logic [1:0] rst_sync_q;
  logic       rst_n_int;
  logic       load;
  logic       step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  mul_ctrl #(.OPW(OPW)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .start_i (start_i),
    .load_o  (load),
    .step_o  (step),
    .done_o  (done_o)
  );

  mul_datapath #(.OPW(OPW)) u_dp (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .load_i (load),
    .step_i (step),
    .a_i    (a_i),
    .b_i    (b_i),
    .acc_o  (product_o)
  );

  p_launch_clears_done_r7: assert property (@(posedge clk) disable iff (!rst_n_int)
    (done_o && load) |=> (!done_o && product_o == '0));

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_n_int |-> (!done_o && product_o == '0));
endmodule

// File: tb/sim_serial_mult.sv
`timescale 1ns/1ps
module sim_serial_mult;
  localparam int OPW = 4;
  localparam int PW  = 2 * OPW;

  logic           clk;
  logic           rst_n;
  logic           start_i;
  logic [OPW-1:0] a_i;
  logic [OPW-1:0] b_i;
  logic [PW-1:0]  product_o;
  logic           done_o;

  int checks;
  int failures;
  bit finished;

  serial_mult #(.OPW(OPW)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .a_i       (a_i),
    .b_i       (b_i),
    .product_o (product_o),
    .done_o    (done_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [PW-1:0] exp_prod(input logic [OPW-1:0] a, input logic [OPW-1:0] b);
    logic [PW-1:0] ea;
    logic [PW-1:0] eb;
    ea = {{(PW-OPW){1'b0}}, a};
    eb = {{(PW-OPW){1'b0}}, b};
    return ea * eb;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Launch at a negedge, then return right after the accepting edge.
  task automatic launch(input logic [OPW-1:0] a, input logic [OPW-1:0] b);
    @(negedge clk);
    a_i = a;
    b_i = b;
    start_i = 1'b1;
    @(posedge clk);
  endtask

  // Full run with start held high beyond completion.
  task automatic run_op(input logic [OPW-1:0] a, input logic [OPW-1:0] b, input string req);
    logic [PW-1:0] e;
    e = exp_prod(a, b);
    launch(a, b);
    repeat (OPW - 1) @(posedge clk);
    @(negedge clk);
    chk(done_o == 1'b0, "R3", done_o, 0);
    @(posedge clk);
    @(negedge clk);
    chk(done_o == 1'b1, "R3", done_o, 1);
    chk(product_o == e, req, product_o, e);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(done_o == 1'b1, "R5", done_o, 1);
    chk(product_o == e, "R4", product_o, e);
    start_i = 1'b0;
  endtask

  initial begin
    checks = 0;
    failures = 0;
    finished = 0;
    void'($urandom(32'h5eed_0042));
    rst_n = 1'b0;
    start_i = 1'b0;
    a_i = '0;
    b_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(done_o == 1'b0, "R1", done_o, 0);
    chk(product_o == '0, "R1", product_o, 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(done_o == 1'b0 && product_o == '0, "R1", done_o, 0);

    // R9 boundary operands
    run_op('0, '0, "R9");
    run_op({OPW{1'b1}}, {OPW{1'b1}}, "R9");
    run_op({OPW{1'b1}}, '0, "R9");
    run_op('0, {OPW{1'b1}}, "R9");
    run_op(4'd1, {OPW{1'b1}}, "R9");

    // R7: launch from done clears flag and accumulator after the accepting edge
    @(negedge clk);
    launch(4'd6, 4'd7);
    @(negedge clk);
    chk(done_o == 1'b0, "R7", done_o, 0);
    chk(product_o == '0, "R7", product_o, 0);
    start_i = 1'b0;
    repeat (OPW) @(posedge clk);
    @(negedge clk);
    chk(product_o == exp_prod(4'd6, 4'd7), "R2", product_o, exp_prod(4'd6, 4'd7));

    // R6: second rising edge mid-run is ignored
    launch(4'd3, 4'd5);
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    start_i = 1'b1;
    a_i = {OPW{1'b1}};
    b_i = {OPW{1'b1}};
    repeat (OPW - 1) @(posedge clk);
    @(negedge clk);
    chk(done_o == 1'b1, "R6", done_o, 1);
    chk(product_o == exp_prod(4'd3, 4'd5), "R6", product_o, exp_prod(4'd3, 4'd5));
    repeat (OPW + 2) @(posedge clk);
    @(negedge clk);
    chk(done_o == 1'b1 && product_o == exp_prod(4'd3, 4'd5), "R6", product_o, exp_prod(4'd3, 4'd5));
    start_i = 1'b0;

    // R8: operand changes after capture have no effect
    launch(4'd9, 4'd11);
    for (int k = 0; k < OPW; k++) begin
      @(negedge clk);
      a_i = OPW'($urandom);
      b_i = OPW'($urandom);
    end
    @(negedge clk);
    chk(done_o == 1'b1, "R8", done_o, 1);
    chk(product_o == exp_prod(4'd9, 4'd11), "R8", product_o, exp_prod(4'd9, 4'd11));
    start_i = 1'b0;

    // R2: constrained random operands
    for (int n = 0; n < 40; n++) begin
      run_op(OPW'($urandom), OPW'($urandom), "R2");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule